// File: doc/BRIEF.md
# Buck Regulator Soft-Start and Hiccup Sequencer

This block orders the start-up and the fault recovery of a digitally controlled buck regulator. It watches a digital code of the internal bias supply and applies a two-threshold power-good test with hysteresis to it. It also watches an active-high enable and an overcurrent flag from the current comparator. From these it drives three outputs. The first is a reference clamp code that the loop uses in place of the full reference while the output comes up. The second is a PWM inhibit: while it is high, both gate drives are held low. The third is a flag that shows the regulator has finished its ramp and is regulating.

A start runs one ramp of the clamp code. The code goes from zero to full scale in single steps, and each step lasts a programmable number of clock cycles. When the current sensor trips, the output shuts down at once. Three silent ramps then time out a recovery pause while the output stays inhibited. A fourth ramp then restarts the output. If the fault is still present, this hiccup cycle repeats without limit. Losing power-good or dropping enable re-arms the whole sequence, so the next start is again a complete ramp.

All control pins are plain level signals. No data stream passes through the block, so it has no handshake.

Top module: `buck_softstart_seq`

## Requirements
- R1: During reset and in the first cycle after it, `ss_ref` is 0, `pwm_inhibit` is 1 and `in_regulation` is 0.
- R2: The power-good condition turns on once `supply_code` is at least POR_RISE (default 172). It turns off once the code falls below POR_FALL (default 148). For codes between the two, it keeps its previous value. Power-good is registered one cycle after `supply_code` is sampled.
- R3: While power-good is off, `pwm_inhibit` is 1, `ss_ref` is 0 and `in_regulation` is 0.
- R4: A driving ramp starts in the cycle after power-good and enable are both seen high. `ss_ref` takes each value from 0 up to 2^REF_W-1 in turn, holding each value for TICK_DIV cycles. `pwm_inhibit` is 0 throughout the ramp.
- R5: When a driving ramp completes, `ss_ref` stays at full scale and `in_regulation` goes to 1.
- R6: When enable is sampled low (with power-good on), the next cycle shows `pwm_inhibit`=1, `ss_ref`=0 and `in_regulation`=0. A later re-enable starts a full ramp from 0.
- R7: An overcurrent trip sampled during a ramp or during regulation gives `pwm_inhibit`=1, `ss_ref`=0 and `in_regulation`=0 in the very next cycle.
- R8: After a trip, `pwm_inhibit` stays high for exactly SILENT_RAMPS×2^REF_W×TICK_DIV cycles (default 768). A driving retry ramp from 0 follows.
- R9: Overcurrent trips during the silent delay do not change its length or its outputs.
- R10: A trip during a retry ramp, or during regulation after one, restarts the full silent delay. This repeats for as long as the fault persists.
- R11: A loss of power-good forces the inhibited waiting state from any state, and it takes priority over enable. The outputs go inhibited two cycles after the supply code is sampled below POR_FALL.
- R12: `in_regulation` is 1 only after a driving ramp has completed. It is never 1 during a ramp or during a delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| supply_code | input | SUP_W | Digital code of the internal bias supply |
| enable_in | input | 1 | Active-high converter enable |
| oc_trip | input | 1 | Overcurrent comparator flag, active high |
| ss_ref | output | REF_W | Soft-start clamp on the loop reference |
| pwm_inhibit | output | 1 | High to stop PWM and hold both gates low |
| in_regulation | output | 1 | High once a driving ramp has reached full scale |

## Verification
The supply code is first stepped into the hysteresis band and then out of it, from below and from above. This shows that the block uses two thresholds and not one. A clean trip followed by a trip peppered with extra pulses during the pause shows that the delay length is fixed and is deaf to further trips. A trip injected during a retry ramp, and a fault held high for several retries, show the hiccup cycle repeating. Enable drops in mid-ramp, and power-good losses coinciding with enable low, show that both re-arm the ramp and that power-good takes priority.

// File: rtl/bss_pkg.sv
package bss_pkg;
  typedef enum logic [2:0] {
    SQ_OFF      = 3'd0,
    SQ_WAIT_PG  = 3'd1,
    SQ_RAMP     = 3'd2,
    SQ_REG      = 3'd3,
    SQ_PAUSE    = 3'd4,
    SQ_RETRY    = 3'd5
  } sq_state_e;

  function automatic logic drives_output(input sq_state_e s);
    return (s == SQ_RAMP) || (s == SQ_REG) || (s == SQ_RETRY);
  endfunction

  function automatic logic ramp_active(input sq_state_e s);
    return (s == SQ_RAMP) || (s == SQ_RETRY) || (s == SQ_PAUSE);
  endfunction
endpackage

// File: rtl/bss_pg_filter.sv
module bss_pg_filter #(
  parameter int SUP_W    = 8,
  parameter int POR_RISE = 172,
  parameter int POR_FALL = 148
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SUP_W-1:0] supply_code,
  output logic             pg_ok
);
  localparam logic [SUP_W-1:0] RISE_C = SUP_W'(POR_RISE);
  localparam logic [SUP_W-1:0] FALL_C = SUP_W'(POR_FALL);

  logic above_rise, above_fall;
  assign above_rise = (supply_code >= RISE_C);
  assign above_fall = (supply_code >= FALL_C);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pg_ok <= 1'b0;
    else        pg_ok <= pg_ok ? above_fall : above_rise;
  end

  // R2: turn-on at the rising threshold
  p_pg_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!pg_ok && above_rise) |=> pg_ok);
  // R2: band keeps an asserted flag
  p_pg_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (pg_ok && above_fall) |=> pg_ok);
  // R2: drop below falling threshold clears it
  p_pg_fall_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!above_fall) |=> !pg_ok);
endmodule

// File: rtl/bss_ramp_gen.sv
module bss_ramp_gen #(
  parameter int REF_W    = 6,
  parameter int TICK_DIV = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             restart,
  output logic [REF_W-1:0] level,
  output logic             done
);
  localparam logic [REF_W-1:0] FULL = {REF_W{1'b1}};
  localparam int DIV_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;

  logic tick;

  generate
    if (TICK_DIV == 1) begin : g_nodiv
      assign tick = 1'b1;
    end else begin : g_div
      localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(TICK_DIV - 1);
      logic [DIV_W-1:0] div_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                div_q <= '0;
        else if (!run || restart)  div_q <= '0;
        else if (div_q == DIV_LAST) div_q <= '0;
        else                       div_q <= div_q + 1'b1;
      end
      assign tick = (div_q == DIV_LAST);
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      level <= '0;
    else if (!run || restart)        level <= '0;
    else if (tick && level != FULL)  level <= level + 1'b1;
  end

  assign done = run && tick && (level == FULL);

  // R4: the clamp code moves by at most one step per cycle while ramping
  p_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !restart) |=> (level == $past(level)) || (level == $past(level) + 1'b1));
  // R4: an idle ramp engine sits at zero
  p_idle_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!run) |=> (level == '0));
endmodule

// File: rtl/bss_seq_fsm.sv
module bss_seq_fsm
  import bss_pkg::*;
#(
  parameter int SILENT_RAMPS = 3
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      pg_ok,
  input  logic      enable_in,
  input  logic      oc_trip,
  input  logic      ramp_done,
  output sq_state_e state,
  output logic      ramp_run,
  output logic      ramp_restart
);
  localparam int SIL_W = (SILENT_RAMPS > 1) ? $clog2(SILENT_RAMPS) : 1;
  localparam logic [SIL_W-1:0] SIL_LAST = SIL_W'(SILENT_RAMPS - 1);

  sq_state_e       nxt;
  logic [SIL_W-1:0] silent_q;
  logic            pause_end;

  assign pause_end = (state == SQ_PAUSE) && ramp_done && (silent_q == SIL_LAST);

  always_comb begin
    nxt = state;
    if (!pg_ok)          nxt = SQ_WAIT_PG;
    else if (!enable_in) nxt = SQ_OFF;
    else begin
      unique case (state)
        SQ_OFF, SQ_WAIT_PG: nxt = SQ_RAMP;
        SQ_RAMP, SQ_RETRY: begin
          if (oc_trip)        nxt = SQ_PAUSE;
          else if (ramp_done) nxt = SQ_REG;
        end
        SQ_REG:   if (oc_trip)   nxt = SQ_PAUSE;
        SQ_PAUSE: if (pause_end) nxt = SQ_RETRY;
        default:  nxt = SQ_WAIT_PG;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= SQ_WAIT_PG;
    else        state <= nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  silent_q <= '0;
    else if (state != SQ_PAUSE)  silent_q <= '0;
    else if (ramp_done)          silent_q <= (silent_q == SIL_LAST) ? '0 : silent_q + 1'b1;
  end

  assign ramp_run     = ramp_active(state);
  assign ramp_restart = (nxt != state) || ((state == SQ_PAUSE) && ramp_done);

  // R7: a trip while driving moves to the silent pause
  p_trip_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pg_ok && enable_in && oc_trip && drives_output(state)) |=> (state == SQ_PAUSE));
  // R9: trips during the pause do not end it early
  p_pause_deaf_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (pg_ok && enable_in && state == SQ_PAUSE && !ramp_done) |=> (state == SQ_PAUSE));
  // R11: power-good loss wins over everything
  p_pg_loss_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!pg_ok) |=> (state == SQ_WAIT_PG));
  // R6: enable low disables
  p_disable_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (pg_ok && !enable_in) |=> (state == SQ_OFF));
  // R8: pause only exits into a retry ramp unless re-armed
  p_pause_exit_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == SQ_PAUSE && pg_ok && enable_in) |=> (state == SQ_PAUSE || state == SQ_RETRY));
endmodule

// File: rtl/buck_softstart_seq.sv
module buck_softstart_seq
  import bss_pkg::*;
#(
  parameter int SUP_W        = 8,
  parameter int POR_RISE     = 172,
  parameter int POR_FALL     = 148,
  parameter int REF_W        = 6,
  parameter int TICK_DIV     = 4,
  parameter int SILENT_RAMPS = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SUP_W-1:0] supply_code,
  input  logic             enable_in,
  input  logic             oc_trip,
  output logic [REF_W-1:0] ss_ref,
  output logic             pwm_inhibit,
  output logic             in_regulation
);
  localparam logic [REF_W-1:0] FULL = {REF_W{1'b1}};

  logic             pg_ok;
  logic             ramp_run, ramp_restart, ramp_done;
  logic [REF_W-1:0] ramp_level;
  sq_state_e        state;

  bss_pg_filter #(.SUP_W(SUP_W), .POR_RISE(POR_RISE), .POR_FALL(POR_FALL)) u_pg (
    .clk(clk), .rst_n(rst_n), .supply_code(supply_code), .pg_ok(pg_ok));

  bss_ramp_gen #(.REF_W(REF_W), .TICK_DIV(TICK_DIV)) u_ramp (
    .clk(clk), .rst_n(rst_n), .run(ramp_run), .restart(ramp_restart),
    .level(ramp_level), .done(ramp_done));

  bss_seq_fsm #(.SILENT_RAMPS(SILENT_RAMPS)) u_fsm (
    .clk(clk), .rst_n(rst_n), .pg_ok(pg_ok), .enable_in(enable_in),
    .oc_trip(oc_trip), .ramp_done(ramp_done), .state(state),
    .ramp_run(ramp_run), .ramp_restart(ramp_restart));

  always_comb begin
    ss_ref = '0;
    if (state == SQ_REG)                            ss_ref = FULL;
    else if (state == SQ_RAMP || state == SQ_RETRY) ss_ref = ramp_level;
  end

  assign pwm_inhibit   = !drives_output(state);
  assign in_regulation = (state == SQ_REG);

  // R5: regulation is entered only from a ramp that stood at full scale
  p_reg_entry_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_regulation) |-> ($past(ss_ref) == FULL) && !$past(pwm_inhibit));
  // R12: regulation flag never coexists with inhibit
  p_reg_flag_r12: assert property (@(posedge clk) disable iff (!rst_n)
    in_regulation |-> !pwm_inhibit);
  // R3: inhibited output carries a zero clamp code
  p_silent_ref_r3: assert property (@(posedge clk) disable iff (!rst_n)
    pwm_inhibit |-> (ss_ref == '0));
endmodule

// File: tb/buck_softstart_seq_tb_top.sv
`timescale 1ns/1ps
module buck_softstart_seq_tb_top;
  localparam int SUP_W = 8, RISE = 172, FALL = 148, REF_W = 6, TD = 4, SIL = 3;
  localparam int FULLV = (1 << REF_W) - 1;
  localparam int RC = (FULLV + 1) * TD;
  localparam int DLY = SIL * RC;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [SUP_W-1:0] sup = '0;
  logic en = 1'b0, oc = 1'b0;
  logic [REF_W-1:0] ss_ref;
  logic pwm_inhibit, in_regulation;

  int checks = 0, failures = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  buck_softstart_seq dut_i (
    .clk(clk), .rst_n(rst_n), .supply_code(sup), .enable_in(en), .oc_trip(oc),
    .ss_ref(ss_ref), .pwm_inhibit(pwm_inhibit), .in_regulation(in_regulation));

  // behavioural model: mode + elapsed-cycle count
  typedef enum int {M_OFF, M_WAIT, M_RMP, M_REG, M_DLY, M_RETRY} mmode_e;
  mmode_e mode = M_WAIT;
  int t = 0;
  bit pg_m = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode = M_WAIT; t = 0; pg_m = 0;
    end else begin
      bit old_pg;
      old_pg = pg_m;
      pg_m = pg_m ? (int'(sup) >= FALL) : (int'(sup) >= RISE);
      if (!old_pg) begin mode = M_WAIT; t = 0; end
      else if (!en) begin mode = M_OFF; t = 0; end
      else begin
        case (mode)
          M_OFF, M_WAIT: begin mode = M_RMP; t = 0; end
          M_RMP, M_RETRY: begin
            if (oc) begin mode = M_DLY; t = 0; end
            else if (t == RC - 1) begin mode = M_REG; t = 0; end
            else t++;
          end
          M_REG: if (oc) begin mode = M_DLY; t = 0; end
          M_DLY: begin
            if (t == DLY - 1) begin mode = M_RETRY; t = 0; end
            else t++;
          end
          default: ;
        endcase
      end
    end
  end

  task automatic chk(input string req, input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      int er, ei, eg;
      string tag;
      case (mode)
        M_WAIT: tag = "R3"; M_OFF: tag = "R6"; M_RMP: tag = "R4";
        M_REG: tag = "R5"; M_DLY: tag = "R8"; default: tag = "R10";
      endcase
      er = (mode == M_RMP || mode == M_RETRY) ? t / TD : (mode == M_REG ? FULLV : 0);
      ei = (mode == M_RMP || mode == M_RETRY || mode == M_REG) ? 0 : 1;
      eg = (mode == M_REG) ? 1 : 0;
      chk(tag, {ss_ref, pwm_inhibit, in_regulation}, {er[REF_W-1:0], ei[0], eg[0]},
          "model {ref,inh,reg}");
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_reg();
    for (int i = 0; i < 5000 && !in_regulation; i++) @(negedge clk);
  endtask

  int cnt;

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    cyc(3);
    // R1 reset state
    chk("R1", ss_ref, 0, "ref in reset");
    chk("R1", pwm_inhibit, 1, "inhibit in reset");
    chk("R1", in_regulation, 0, "reg in reset");
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", pwm_inhibit, 1, "inhibit after reset");

    // R3 / R2: no power-good below, then inside the band
    en = 1'b1;
    cyc(6);
    chk("R3", pwm_inhibit, 1, "inhibit without power-good");
    sup = 8'd160;
    cyc(6);
    chk("R2", pwm_inhibit, 1, "band from below stays off");
    sup = 8'd180;
    cyc(3);
    chk("R4", pwm_inhibit, 0, "ramp started");
    cyc(RC / 2);
    chk("R12", in_regulation, 0, "no reg flag mid ramp");
    wait_reg();
    chk("R5", ss_ref, FULLV, "full scale in regulation");

    // R2 hysteresis from above, R11 loss
    sup = 8'd160;
    cyc(6);
    chk("R2", in_regulation, 1, "band from above stays on");
    sup = 8'd140;
    cyc(2);
    chk("R11", pwm_inhibit, 1, "inhibit two cycles after loss");
    chk("R11", in_regulation, 0, "reg flag cleared on loss");
    sup = 8'd200;
    cyc(3 + RC / 3);

    // R6 disable mid ramp and re-enable
    en = 1'b0;
    @(negedge clk);
    chk("R6", pwm_inhibit, 1, "inhibit on disable");
    chk("R6", ss_ref, 0, "ref zero on disable");
    cyc(5);
    en = 1'b1;
    cyc(2);
    chk("R6", ss_ref, 0, "re-enable restarts at zero");
    wait_reg();

    // R7 / R8 clean trip
    oc = 1'b1;
    @(negedge clk);
    oc = 1'b0;
    chk("R7", pwm_inhibit, 1, "inhibit after trip");
    chk("R7", in_regulation, 0, "reg flag after trip");
    cnt = 1;
    while (pwm_inhibit && cnt < 5000) begin @(negedge clk); if (pwm_inhibit) cnt++; end
    chk("R8", cnt, DLY, "silent delay length");
    chk("R8", ss_ref, 0, "retry ramp starts at zero");
    wait_reg();

    // R9 trips during the delay are ignored
    oc = 1'b1;
    @(negedge clk);
    oc = 1'b0;
    cnt = 1;
    while (pwm_inhibit && cnt < 5000) begin
      oc = (cnt == 50 || cnt == 51 || cnt == 400 || cnt == DLY - 1);
      @(negedge clk);
      if (pwm_inhibit) cnt++;
    end
    oc = 1'b0;
    chk("R9", cnt, DLY, "delay length with extra trips");

    // R10 trip during the retry ramp
    cyc(RC / 4);
    oc = 1'b1;
    @(negedge clk);
    oc = 1'b0;
    chk("R10", pwm_inhibit, 1, "retry trip restarts delay");
    cyc(DLY + 2);
    chk("R10", pwm_inhibit, 0, "retry after repeated delay");

    // R10 persistent fault: several hiccup cycles
    oc = 1'b1;
    cyc(3 * (DLY + 1) + 5);
    chk("R10", pwm_inhibit, 1, "persistent fault keeps hiccup");
    // R11 power-good loss during delay with enable low
    sup = 8'd100;
    en = 1'b0;
    oc = 1'b0;
    cyc(4);
    chk("R11", pwm_inhibit, 1, "waiting after loss");
    en = 1'b1;
    cyc(4);
    chk("R11", pwm_inhibit, 1, "enable alone cannot start");
    sup = 8'd200;
    cyc(3);
    chk("R4", ss_ref, 0, "fresh ramp from zero");
    wait_reg();
    chk("R5", in_regulation, 1, "regulating after final ramp");

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule